// File: doc/BRIEF.md
# Robbed-Bit Signaling Capture Unit

This block sits behind a T1 framer and watches the stream of 24 DS0 channel bytes. With each byte comes its channel index, its frame number within the multiframe, the framing mode and a loss-of-sync flag. The block takes the robbed signaling bit (the LSB) out of the signaling frames and collects it in a shadow store while the multiframe runs. On the last byte of the multiframe it moves the whole set into twelve byte-wide host-readable registers in one cycle.

In D4 mode only A and B exist. The C and D positions are then refilled with the A and B values that were shown before the boundary, so a host that reads once per 3 ms sees the same layout in either mode. While sync is lost, nothing is captured or transferred, and the registers keep their last good contents. Two sticky status bits report a multiframe boundary and a change of signaling. Each has a mask bit, and the pair drives an active-low interrupt.

Top module: `rbs_capture`

## Requirements
- R1: After reset, every signaling register, the status register and the mask register read 0, and irq_n is high.
- R2: Signaling register BASE+k (k = 0..11) holds group k/3 (0 = A, 1 = B, 2 = A/C, 3 = B/D). Bit i of that register is channel (k%3)*8+i+1, where channel 1 is the byte with ch_idx 0.
- R3: In ESF mode (esf_mode = 1), A, B, C and D are the LSBs of each channel byte in frames 6, 12, 18 and 24. LSBs in any other frame have no effect on the registers.
- R4: In D4 mode (esf_mode = 0), A and B are the LSBs of frames 6 and 12. At the boundary, the A/C group takes the A values and the B/D group takes the B values that the registers held just before that boundary.
- R5: The registers change only on the boundary byte, which is ch_idx 23 of frame 24 in ESF or frame 12 in D4. A read partway through a multiframe returns the previous multiframe's contents.
- R6: While sync_lost is 1, bytes and boundaries are ignored. The registers keep their values and no status bit is set.
- R7: Status bit 0 (change) is set at a boundary when the new contents differ from the old. In ESF all four groups are compared; in D4 only A and B are compared.
- R8: Status bit 1 (multiframe) is set at every accepted boundary.
- R9: Reading the status register at BASE+12 returns its value and clears it. A status event in the same cycle as the read keeps its bit set.
- R10: The mask register at BASE+13 is written and read on bits 1:0, in the same positions as the status bits. irq_n is low exactly when some status bit and its mask bit are both 1.
- R11: rd_data presents the addressed value in the cycle after rd_en. Addresses outside BASE..BASE+13 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | A channel byte is present |
| ch_byte | input | 8 | Channel byte |
| ch_idx | input | 5 | Channel index, 0..23 |
| frame_no | input | 5 | Frame number within the multiframe, starting at 1 |
| esf_mode | input | 1 | 1 = ESF (24 frames), 0 = D4 (12 frames) |
| sync_lost | input | 1 | Framer has lost sync |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Read data, one cycle after rd_en |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 8 | Write data (mask register only) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A shadow bit captured from the wrong frame or channel stays hidden until the next boundary. It then shows in one register bit that a single multiframe, about 600 cycles, exposes. A wrong D4 refill shows in the A/C and B/D registers only one boundary later, so the bench runs D4 twice in a row. A status or mask fault shows on irq_n in the cycle after the event, and on the status readback one cycle after the read.

// File: rtl/rbs_capture.sv
module rbs_capture #(
  parameter int NCH = 24,
  parameter logic [7:0] BASE = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_valid,
  input  logic [7:0] ch_byte,
  input  logic [4:0] ch_idx,
  input  logic [4:0] frame_no,
  input  logic       esf_mode,
  input  logic       sync_lost,
  input  logic       rd_en,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       irq_n
);
  localparam int RPG  = NCH / 8;
  localparam int NREG = 4 * RPG;
  localparam int RW   = $clog2(NREG);
  localparam logic [7:0] STAT_A = BASE + 8'(NREG);
  localparam logic [7:0] MASK_A = STAT_A + 8'd1;

  logic [3:0][NCH-1:0] shadow, shadow_nx, live, live_nx;
  logic [NREG-1:0][7:0] rb;
  logic [1:0] stat, mask;
  logic [7:0] off;

  wire take   = ch_valid && !sync_lost;
  wire mf_end = take && ch_idx == 5'(NCH-1) && frame_no == (esf_mode ? 5'd24 : 5'd12);
  wire chg    = esf_mode ? (live_nx != live) : (live_nx[1:0] != live[1:0]);
  wire rd_st  = rd_en && rd_addr == STAT_A;
  wire [1:0] ev = mf_end ? {1'b1, chg} : 2'b00;

  always_comb begin
    shadow_nx = shadow;
    if (take) begin
      if (frame_no == 5'd6)                   shadow_nx[0][ch_idx] = ch_byte[0];
      else if (frame_no == 5'd12)             shadow_nx[1][ch_idx] = ch_byte[0];
      else if (esf_mode && frame_no == 5'd18) shadow_nx[2][ch_idx] = ch_byte[0];
      else if (esf_mode && frame_no == 5'd24) shadow_nx[3][ch_idx] = ch_byte[0];
    end
    live_nx = esf_mode ? shadow_nx : {live[1], live[0], shadow_nx[1], shadow_nx[0]};
  end

  for (genvar k = 0; k < NREG; k++) begin : g_rb
    assign rb[k] = live[k/RPG][(k%RPG)*8 +: 8];
  end

  assign off   = rd_addr - BASE;
  assign irq_n = ~|(stat & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= '0;
      live    <= '0;
      stat    <= '0;
      mask    <= '0;
      rd_data <= '0;
    end else begin
      shadow <= shadow_nx;
      if (mf_end) live <= live_nx;
      stat <= (rd_st ? 2'b00 : stat) | ev;
      if (wr_en && wr_addr == MASK_A) mask <= wr_data[1:0];
      if (rd_en) begin
        if (rd_addr >= BASE && rd_addr < STAT_A) rd_data <= rb[off[RW-1:0]];
        else if (rd_addr == STAT_A)              rd_data <= {6'b0, stat};
        else if (rd_addr == MASK_A)              rd_data <= {6'b0, mask};
        else                                     rd_data <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/rbs_capture_chk.sv
module rbs_capture_chk #(
  parameter int NCH = 24,
  parameter logic [7:0] BASE = 8'h60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ch_valid,
  input logic [4:0]       ch_idx,
  input logic [4:0]       frame_no,
  input logic             esf_mode,
  input logic             sync_lost,
  input logic             rd_en,
  input logic [7:0]       rd_addr,
  input logic [4*NCH-1:0] live_q,
  input logic [1:0]       stat_q,
  input logic             irq_n
);
  localparam logic [7:0] STAT_A = BASE + 8'(4 * (NCH / 8));

  AST_FROZEN_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> $stable(live_q)); // R6
  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_q) |-> $past(ch_valid && ch_idx == 5'(NCH-1) && frame_no == (esf_mode ? 5'd24 : 5'd12))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == STAT_A && !ch_valid) |=> stat_q == 2'b00); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q == 2'b00 |-> irq_n); // R10
  AST_NO_STAT_WHEN_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost && !(rd_en && rd_addr == STAT_A)) |=> $stable(stat_q)); // R6
endmodule

bind rbs_capture rbs_capture_chk #(.NCH(NCH), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_idx(ch_idx),
  .frame_no(frame_no), .esf_mode(esf_mode), .sync_lost(sync_lost),
  .rd_en(rd_en), .rd_addr(rd_addr), .live_q(live), .stat_q(stat), .irq_n(irq_n)
);

// File: tb/test_rbs_capture.sv
module test_rbs_capture;
  localparam logic [7:0] BASE = 8'h60;
  localparam logic [7:0] STAT = 8'h6C;
  localparam logic [7:0] MASK = 8'h6D;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ch_valid = 1'b0, esf_mode = 1'b1, sync_lost = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0, irq_n;
  logic [7:0] ch_byte = '0, rd_addr = '0, rd_data, wr_addr = '0, wr_data = '0;
  logic [4:0] ch_idx = '0, frame_no = 5'd1;

  rbs_capture i_rbs_capture (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_byte(ch_byte),
    .ch_idx(ch_idx), .frame_no(frame_no), .esf_mode(esf_mode),
    .sync_lost(sync_lost), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_n(irq_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] expq[$];
  string tagq[$];
  logic [23:0] m[4];
  logic [1:0] stat_m = 2'b00, mask_m = 2'b00;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      check(tagq.pop_front(), rd_data, expq.pop_front());
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    expq.push_back(e); tagq.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_mask(input logic [1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = MASK; wr_data = {6'b0, v};
    @(negedge clk);
    wr_en = 1'b0;
    mask_m = v;
  endtask

  function automatic logic [7:0] exp_reg(int k);
    return m[k/3][(k%3)*8 +: 8];
  endfunction

  task automatic verify_regs(string tag);
    for (int k = 0; k < 12; k++) rd(BASE + 8'(k), exp_reg(k), tag);
  endtask

  task automatic read_stat(string tag);
    rd(STAT, {6'b0, stat_m}, tag);
    stat_m = 2'b00;
    @(negedge clk);
    check("R10 irq after clear", irq_n, 1);
  endtask

  task automatic send_mf(input bit esf, input logic [23:0] a, b, c, d,
                         input bit lost, input bit peek, input bit rd_end);
    int nf = esf ? 24 : 12;
    logic [23:0] nw[4];
    logic chg;
    for (int f = 1; f <= nf; f++) begin
      for (int ch = 0; ch < 24; ch++) begin
        @(negedge clk);
        ch_valid = 1'b1; esf_mode = esf; sync_lost = lost;
        frame_no = 5'(f); ch_idx = 5'(ch);
        ch_byte = 8'($urandom);
        if (f == 6)  ch_byte[0] = a[ch];
        if (f == 12) ch_byte[0] = b[ch];
        if (esf && f == 18) ch_byte[0] = c[ch];
        if (esf && f == 24) ch_byte[0] = d[ch];
        if (rd_end && f == nf && ch == 23) begin
          rd_en = 1'b1; rd_addr = STAT;
          expq.push_back({6'b0, stat_m}); tagq.push_back("R9 read at boundary");
        end
      end
      if (peek && f == 13) begin
        @(negedge clk);
        ch_valid = 1'b0;
        rd(BASE, exp_reg(0), "R5 mid-multiframe");
      end
    end
    @(negedge clk);
    ch_valid = 1'b0; rd_en = 1'b0; sync_lost = 1'b0;
    if (!lost) begin
      nw[0] = a; nw[1] = b;
      nw[2] = esf ? c : m[0];
      nw[3] = esf ? d : m[1];
      chg = (nw[0] != m[0]) || (nw[1] != m[1]) ||
            (esf && ((nw[2] != m[2]) || (nw[3] != m[3])));
      stat_m = rd_end ? {1'b1, chg} : (stat_m | {1'b1, chg});
      for (int g = 0; g < 4; g++) m[g] = nw[g];
    end else if (rd_end) stat_m = 2'b00;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int g = 0; g < 4; g++) m[g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq_n reset", irq_n, 1);
    for (int k = 0; k < 14; k++) rd(BASE + 8'(k), 8'h00, "R1 reset value");
    rd(8'h70, 8'h00, "R11 unmapped");
    rd(8'h5F, 8'h00, "R11 unmapped");

    wr_mask(2'b01);
    rd(MASK, 8'h01, "R10 mask readback");

    send_mf(1, 24'hA5C3F1, 24'h0F1E2D, 24'h123456, 24'h800001, 0, 0, 0);
    verify_regs("R2 layout");
    @(negedge clk);
    check("R10 irq on change", irq_n, 0);
    read_stat("R7 R8 first ESF");

    send_mf(1, 24'h5A3C0E, 24'hF0E1D2, 24'hEDCBA9, 24'h7FFFFE, 0, 1, 0);
    verify_regs("R3 ESF capture");
    read_stat("R7 ESF change");

    send_mf(1, 24'h5A3C0E, 24'hF0E1D2, 24'hEDCBA9, 24'h7FFFFE, 0, 0, 0);
    @(negedge clk);
    check("R10 masked mf", irq_n, 1);
    read_stat("R8 no change");

    send_mf(1, 24'h111111, 24'h222222, 24'h333333, 24'h444444, 1, 0, 0);
    verify_regs("R6 frozen");
    read_stat("R6 no status");

    send_mf(0, 24'hC0FFEE, 24'h0BADF0, 24'h000000, 24'h000000, 0, 0, 0);
    verify_regs("R4 D4 first");
    read_stat("R7 D4 change");
    send_mf(0, 24'hC0FFEE, 24'h0BADF0, 24'hFFFFFF, 24'hFFFFFF, 0, 0, 0);
    verify_regs("R4 D4 refill");
    read_stat("R7 D4 compares A B only");

    send_mf(1, 24'hA5C3F1, 24'h0F1E2D, 24'h123456, 24'h800001, 0, 0, 1);
    read_stat("R9 event wins");

    wr_mask(2'b10);
    send_mf(1, 24'hA5C3F1, 24'h0F1E2D, 24'h123456, 24'h800001, 0, 0, 0);
    @(negedge clk);
    check("R10 mf irq", irq_n, 0);
    read_stat("R8 mf only");
    verify_regs("R3 repeat");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule